// File: doc/BRIEF.md
# Receive Error Tally Counters

This block keeps three statistics counters for a network receiver. One counts frames that passed the address filter but failed their CRC, one counts frames that passed the filter with a framing alignment fault, and one counts frames that were lost. A frame counts as lost when buffer space ran out, when the receive FIFO overran, or when a good frame arrived while reception was switched off. The receive path supplies one-cycle event strobes, and the block turns them into at most one increment per counter per cycle.

A host loads each counter through a narrow write port. Each write stores the bit-inverted data word, so an all-ones write clears a counter. Reads are the plain output buses. Neither the hardware reset nor the software-reset hold alters a counter's contents. While the software-reset hold is asserted, counting stops. When a counter wraps from all ones to zero it sets a sticky flag. The interrupt request is that flag gated by its mask bit, and an acknowledge strobe clears the flag.

Top module: `rx_err_tally`

## Requirements
- R1: After `rst_n` is released all `irq_req` bits are 0. Asserting `rst_n` low does not change any counter value.
- R2: A host write (`host_wr`=1) stores the bitwise inverse of `host_wdata` into the counter selected by `host_sel`, and the count outputs show it on the next cycle. Select codes: 0 is the CRC counter, 1 is the alignment counter, 2 is the missed counter, and 3 selects nothing, so no counter changes.
- R3: `crc_count` increments by one in a cycle where `pkt_accept`, `crc_err` and not `align_err` hold.
- R4: `align_count` increments by one in a cycle where `pkt_accept` and `align_err` hold, whatever `crc_err` is.
- R5: `miss_count` increments by exactly one in a cycle where `pkt_end` holds together with at least one of: `no_rsrc`, `fifo_ovr`, or (`pkt_valid` and `rx_disabled`). A good frame with reception enabled does not count.
- R6: While `sw_rst` is 1 no counter increments. Host writes still take effect.
- R7: An increment from all ones gives zero and sets that counter's sticky flag. `irq_req[k]` is flag k ANDed with `irq_mask[k]`. Bit order: 0 is CRC, 1 is alignment, 2 is missed.
- R8: `irq_ack[k]`=1 clears flag k on the next cycle. A wrap in the same cycle takes priority and leaves the flag set.
- R9: When a host write and an increment target the same counter in the same cycle, the counter takes the written (inverted) value.
- R10: Error strobes do not count unless `pkt_accept` is high. Missed conditions do not count unless `pkt_end` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low; clears flags only |
| sw_rst | input | 1 | Software-reset hold; freezes counting |
| rx_disabled | input | 1 | Reception switched off (level) |
| pkt_accept | input | 1 | Frame passed the address filter (strobe) |
| crc_err | input | 1 | Accepted frame has a CRC fault |
| align_err | input | 1 | Accepted frame has an alignment fault |
| pkt_end | input | 1 | A frame finished arriving (strobe) |
| no_rsrc | input | 1 | No buffer space for the frame |
| fifo_ovr | input | 1 | Receive FIFO overran |
| pkt_valid | input | 1 | The finished frame was good |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Counter select for the write |
| host_wdata | input | CNT_W | Write data, stored inverted |
| irq_mask | input | 3 | Interrupt enable per counter |
| irq_ack | input | 3 | Write-one-to-clear flag acknowledge |
| crc_count | output | CNT_W | CRC error count |
| align_count | output | CNT_W | Alignment error count |
| miss_count | output | CNT_W | Missed frame count |
| irq_req | output | 3 | Masked wrap interrupt requests |

## Verification
The bench builds the block with the default `CNT_W` of 16. Because writes are inverted, a single write of zero preloads any counter to FFFFh, so one event is enough to reach the wrap and its interrupt. A table of strobe combinations covers the qualification rules, and each row is checked against running totals. Directed tests then cover the freeze, the retention across hardware reset, the acknowledge race and the write-versus-increment race.

// File: rtl/rxt_pkg.sv
package rxt_pkg;
  localparam int NUM_TALLY = 3;
  typedef enum logic [1:0] {
    SEL_CRC   = 2'd0,
    SEL_ALIGN = 2'd1,
    SEL_MISS  = 2'd2,
    SEL_NONE  = 2'd3
  } tally_sel_e;
endpackage

// File: rtl/tally_qualify.sv
module tally_qualify (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_disabled,
  input  logic       pkt_accept,
  input  logic       crc_err,
  input  logic       align_err,
  input  logic       pkt_end,
  input  logic       no_rsrc,
  input  logic       fifo_ovr,
  input  logic       pkt_valid,
  output logic [2:0] inc
);
  logic crc_hit, align_hit, miss_hit, lost_cond;

  // a CRC fault is hidden by an alignment fault on the same frame
  assign crc_hit   = pkt_accept & crc_err & ~align_err;
  assign align_hit = pkt_accept & align_err;
  assign lost_cond = no_rsrc | fifo_ovr | (pkt_valid & rx_disabled);
  // a single reduced term gives one increment per frame however many causes hold
  assign miss_hit  = pkt_end & lost_cond;

  assign inc = {miss_hit, align_hit, crc_hit};

  AST_CRC_NOT_WITH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    inc[0] |-> !align_err && pkt_accept);                      // R3
  AST_EVENT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_accept |-> !inc[0] && !inc[1]);                       // R10
  AST_MISS_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_end |-> !inc[2]);                                     // R5
endmodule

// File: rtl/tally_cell.sv
module tally_cell #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             inc,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ack,
  output logic [CNT_W-1:0] count,
  output logic             wrap_flag,
  output logic             wrap_evt
);
  function automatic logic [CNT_W-1:0] tally_store(input logic [CNT_W-1:0] d);
    return ~d;
  endfunction

  function automatic logic [CNT_W-1:0] tally_next(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic tally_wraps(input logic [CNT_W-1:0] c);
    return &c;
  endfunction

  logic [CNT_W-1:0] count_q;
  logic             flag_q;
  logic             bump;

  // a write takes priority over an increment; the software hold freezes counting only
  assign bump     = inc & ~sw_rst & ~wr_en;
  assign wrap_evt = bump & tally_wraps(count_q);

  // no reset term: the count survives both kinds of reset
  always_ff @(posedge clk) begin
    if (wr_en)     count_q <= tally_store(wr_data);
    else if (bump) count_q <= tally_next(count_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap_evt) flag_q <= 1'b1;
    else if (ack)      flag_q <= 1'b0;
  end

  assign count     = count_q;
  assign wrap_flag = flag_q;

  AST_WRITE_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count_q == ~$past(wr_data));                     // R2
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst && !wr_en) |=> $stable(count_q));                  // R6
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en && !sw_rst) |=> count_q == $past(count_q) + 1'b1); // R3
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en && !sw_rst && (&count_q)) |=> flag_q && count_q == '0); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wrap_evt) |=> !flag_q);                           // R8
endmodule

// File: rtl/rx_err_tally.sv
module rx_err_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             rx_disabled,
  input  logic             pkt_accept,
  input  logic             crc_err,
  input  logic             align_err,
  input  logic             pkt_end,
  input  logic             no_rsrc,
  input  logic             fifo_ovr,
  input  logic             pkt_valid,
  input  logic             host_wr,
  input  logic [1:0]       host_sel,
  input  logic [CNT_W-1:0] host_wdata,
  input  logic [2:0]       irq_mask,
  input  logic [2:0]       irq_ack,
  output logic [CNT_W-1:0] crc_count,
  output logic [CNT_W-1:0] align_count,
  output logic [CNT_W-1:0] miss_count,
  output logic [2:0]       irq_req
);
  import rxt_pkg::*;

  localparam int NT = NUM_TALLY;

  logic [NT-1:0]    inc;
  logic [NT-1:0]    wr_hit;
  logic [NT-1:0]    flags;
  logic [NT-1:0]    wraps;
  logic [CNT_W-1:0] cnt [NT];

  tally_qualify u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_disabled (rx_disabled),
    .pkt_accept  (pkt_accept),
    .crc_err     (crc_err),
    .align_err   (align_err),
    .pkt_end     (pkt_end),
    .no_rsrc     (no_rsrc),
    .fifo_ovr    (fifo_ovr),
    .pkt_valid   (pkt_valid),
    .inc         (inc)
  );

  for (genvar k = 0; k < NT; k++) begin : g_cell
    assign wr_hit[k] = host_wr && (host_sel == 2'(k));
    tally_cell #(.CNT_W(CNT_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_rst    (sw_rst),
      .inc       (inc[k]),
      .wr_en     (wr_hit[k]),
      .wr_data   (host_wdata),
      .ack       (irq_ack[k]),
      .count     (cnt[k]),
      .wrap_flag (flags[k]),
      .wrap_evt  (wraps[k])
    );
  end

  assign crc_count   = cnt[SEL_CRC];
  assign align_count = cnt[SEL_ALIGN];
  assign miss_count  = cnt[SEL_MISS];
  assign irq_req     = flags & irq_mask;

  AST_NONE_SEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel == SEL_NONE) |-> wr_hit == '0);                  // R2
  AST_WRITE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));                                         // R2
  AST_IRQ_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(wraps[0]));                      // R7
endmodule

// File: tb/rx_err_tally_tb_top.sv
module rx_err_tally_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 1'b0, rx_disabled = 1'b0, pkt_accept = 1'b0, crc_err = 1'b0;
  logic align_err = 1'b0, pkt_end = 1'b0, no_rsrc = 1'b0, fifo_ovr = 1'b0, pkt_valid = 1'b0;
  logic host_wr = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [W-1:0] host_wdata = '0;
  logic [2:0] irq_mask = 3'b000, irq_ack = 3'b000;
  logic [W-1:0] crc_count, align_count, miss_count;
  logic [2:0] irq_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_err_tally #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .rx_disabled(rx_disabled),
    .pkt_accept(pkt_accept), .crc_err(crc_err), .align_err(align_err),
    .pkt_end(pkt_end), .no_rsrc(no_rsrc), .fifo_ovr(fifo_ovr), .pkt_valid(pkt_valid),
    .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
    .irq_mask(irq_mask), .irq_ack(irq_ack),
    .crc_count(crc_count), .align_count(align_count), .miss_count(miss_count),
    .irq_req(irq_req)
  );

  // bits: accept crc align end norsrc fifo valid rxdis | dcrc dalign dmiss
  localparam logic [10:0] VEC [12] = '{
    11'b1_1_0_0_0_0_0_0_100,
    11'b1_0_1_0_0_0_0_0_010,
    11'b1_1_1_0_0_0_0_0_010,
    11'b0_1_0_0_0_0_0_0_000,
    11'b0_0_1_0_0_0_0_0_000,
    11'b0_0_0_1_1_0_0_0_001,
    11'b0_0_0_1_0_1_0_0_001,
    11'b0_0_0_1_0_0_1_1_001,
    11'b0_0_0_1_0_0_1_0_000,
    11'b0_0_0_1_1_1_1_1_001,
    11'b0_0_0_0_1_1_0_0_000,
    11'b1_1_0_1_0_1_0_0_101
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    pkt_accept = 0; crc_err = 0; align_err = 0; pkt_end = 0;
    no_rsrc = 0; fifo_ovr = 0; pkt_valid = 0; rx_disabled = 0;
    host_wr = 0; irq_ack = 3'b000;
  endtask

  task automatic hwrite(input logic [1:0] sel, input logic [W-1:0] d);
    host_wr = 1; host_sel = sel; host_wdata = d;
    cyc();
    host_wr = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ec, ea, em;
    cyc(); cyc();
    rst_n = 1;
    cyc();
    check("R1 irq after reset", 16'(irq_req), 16'h0000);

    // R2: inverted writes, clear all
    hwrite(2'd0, 16'hFFFF);
    hwrite(2'd1, 16'hFFFF);
    hwrite(2'd2, 16'hFFFF);
    check("R2 crc cleared", crc_count, 16'h0000);
    check("R2 align cleared", align_count, 16'h0000);
    check("R2 miss cleared", miss_count, 16'h0000);
    hwrite(2'd1, 16'h1234);
    check("R2 align inverted", align_count, 16'hEDCB);
    hwrite(2'd3, 16'h0000);
    check("R2 sel3 crc", crc_count, 16'h0000);
    check("R2 sel3 align", align_count, 16'hEDCB);
    check("R2 sel3 miss", miss_count, 16'h0000);
    hwrite(2'd1, 16'hFFFF);

    // table of event patterns: R3 R4 R5 R10
    ec = '0; ea = '0; em = '0;
    for (int i = 0; i < 12; i++) begin
      {pkt_accept, crc_err, align_err, pkt_end, no_rsrc, fifo_ovr, pkt_valid, rx_disabled} = VEC[i][10:3];
      cyc();
      clear_strobes();
      ec = ec + 16'(VEC[i][2]);
      ea = ea + 16'(VEC[i][1]);
      em = em + 16'(VEC[i][0]);
      check("R3/R10 crc table", crc_count, ec);
      check("R4/R10 align table", align_count, ea);
      check("R5/R10 miss table", miss_count, em);
    end

    // R6: software hold freezes counting, writes still land
    sw_rst = 1;
    pkt_accept = 1; crc_err = 1; pkt_end = 1; fifo_ovr = 1;
    cyc();
    pkt_accept = 0; align_err = 0; crc_err = 0;
    pkt_accept = 1; align_err = 1;
    cyc();
    clear_strobes();
    check("R6 crc frozen", crc_count, ec);
    check("R6 align frozen", align_count, ea);
    check("R6 miss frozen", miss_count, em);
    hwrite(2'd2, 16'hFFF0);
    check("R6 write during hold", miss_count, 16'h000F);
    sw_rst = 0;
    em = 16'h000F;

    // R1: hardware reset keeps counts
    rst_n = 0;
    cyc(); cyc();
    rst_n = 1;
    cyc();
    check("R1 crc kept", crc_count, ec);
    check("R1 align kept", align_count, ea);
    check("R1 miss kept", miss_count, em);

    // R7: wrap sets flag, mask gates request
    irq_mask = 3'b001;
    hwrite(2'd0, 16'h0000);
    check("R7 preload", crc_count, 16'hFFFF);
    pkt_accept = 1; crc_err = 1;
    cyc();
    clear_strobes();
    check("R7 wrap to zero", crc_count, 16'h0000);
    check("R7 irq crc", 16'(irq_req), 16'h0001);
    hwrite(2'd1, 16'h0000);
    pkt_accept = 1; align_err = 1;
    cyc();
    clear_strobes();
    check("R7 masked align", 16'(irq_req), 16'h0001);
    irq_mask = 3'b011;
    cyc();
    check("R7 sticky align", 16'(irq_req), 16'h0003);

    // R8: acknowledge clears, wrap beats ack
    irq_ack = 3'b010;
    cyc();
    clear_strobes();
    check("R8 ack clears", 16'(irq_req), 16'h0001);
    hwrite(2'd0, 16'h0000);
    irq_ack = 3'b001; pkt_accept = 1; crc_err = 1;
    cyc();
    clear_strobes();
    check("R8 wrap beats ack", 16'(irq_req), 16'h0001);
    irq_ack = 3'b001;
    cyc();
    clear_strobes();
    check("R8 later ack", 16'(irq_req), 16'h0000);

    // R9: write wins over increment
    host_wr = 1; host_sel = 2'd0; host_wdata = 16'hFFAF;
    pkt_accept = 1; crc_err = 1;
    cyc();
    clear_strobes();
    check("R9 write wins", crc_count, 16'h0050);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule